// File: doc/BRIEF.md
# CAN Bit Timer with Edge Resynchronization

The block turns the system clock into the time base of a CAN bit. A programmable prescaler produces a time-quantum tick. Each bit runs through a one-quantum sync segment, a first phase segment and a second phase segment. The block emits a one-clock pulse at the start of every bit. It also emits a one-clock sample strobe together with the value of the bus line taken at the sample point, which is the end of the first phase segment.

The block watches the receive line for falling (recessive-to-dominant) edges and measures where each edge lands inside the current bit. While hard synchronization is enabled, any falling edge restarts the bit at its sync segment. Otherwise the block resynchronizes: it lengthens the first phase segment or shortens the second one. The correction is in whole quanta and is capped by a programmable jump width. A protocol engine drives the configuration fields, a flag that says the node itself is driving dominant, and the hard-sync enable. It consumes the strobes and the sampled bit.

Top module: `can_bit_timer`

## Requirements
- R1: `tq_tick` is a one-clock pulse that repeats every `cfg_div`+2 clocks, so the spacing ranges from 2 to 65 clocks. Hard synchronization and full early correction restart this count.
- R2: The first phase segment lasts `cfg_ph1`+1 quanta and the second lasts `cfg_ph2`+1 quanta. Without edges, a bit lasts 1 + (`cfg_ph1`+1) + (`cfg_ph2`+1) quanta. `bit_start` pulses for one clock, one clock after the tick that ends a bit, and never in the same cycle as `sample_stb`.
- R3: `sample_stb` pulses for one clock, one clock after the tick that ends the first phase segment. `sample_bit` then holds the `rx` value taken at that clock edge. Logic 1 on `rx` is recessive and logic 0 is dominant.
- R4: Only a 1-to-0 transition of `rx` is treated as an edge. A 0-to-1 transition leaves the bit timing unchanged.
- R5: Let q be the quantum index within the bit, with 0 for the sync segment. An edge seen while q lies in the first phase segment has a phase error of +q. If that error exceeds the jump width, the first phase segment of the current bit is lengthened by exactly the jump width.
- R6: An edge in the second phase segment has a phase error of minus the quanta left to the nominal bit end, counting the current quantum. If the size of that error exceeds the jump width, the second phase segment is shortened by exactly the jump width.
- R7: If the size of the error is at most the jump width, the correction is the full error. In the first phase segment, the segment is lengthened by q. In the second phase segment, the bit restarts at once and `bit_start` pulses on the next clock.
- R8: The jump width is `cfg_jump`+1 quanta, limited to at most the length of the second phase segment.
- R9: No resynchronization happens on an edge seen while `tx_dom` is 1, and such an edge does not use up the bit's single allowance.
- R10: At most one resynchronization is made per bit. Later edges in the same bit leave its length unchanged.
- R11: While `hsync_en` is 1, every falling edge restarts the bit at its sync segment, whatever its phase. `bit_start` pulses on the next clock.
- R12: An edge in the sync segment has zero phase error. It leaves the bit length unchanged and uses up the bit's allowance.
- R13: During reset, `tq_tick`, `sample_stb` and `bit_start` are 0 and `sample_bit` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_div | input | 6 | Prescaler field, divisor = field + 2 |
| cfg_ph1 | input | 4 | First phase segment field, length = field + 1 |
| cfg_ph2 | input | 3 | Second phase segment field, length = field + 1 |
| cfg_jump | input | 2 | Jump width field, width = field + 1 |
| rx | input | 1 | Bus receive line, 1 = recessive |
| tx_dom | input | 1 | Node is currently driving dominant |
| hsync_en | input | 1 | Hard synchronization enable |
| tq_tick | output | 1 | Time-quantum tick |
| sample_stb | output | 1 | Sample point strobe |
| sample_bit | output | 1 | Bus value at the sample point |
| bit_start | output | 1 | Start-of-bit strobe |

## Verification
A corrupted prescaler count shows up within one divisor period as a misplaced `tq_tick`. A corrupted segment counter or segment extension moves `sample_stb` or `bit_start` within the same bit. A wrong resynchronization flag, or a wrong correction amount, shows up as an interval between two `bit_start` pulses that differs from the requirement, at the end of the very bit where the edge fell. A behavioural model of quantum position, compared on every clock, therefore catches any state fault within one bit time, and interval checks tie each correction case to its exact length.

// File: rtl/can_bit_timer.sv
module can_bit_timer #(
  parameter int PSC_W = 6,
  parameter int PH1_W = 4,
  parameter int PH2_W = 3,
  parameter int SJW_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [PSC_W-1:0] cfg_div,
  input  logic [PH1_W-1:0] cfg_ph1,
  input  logic [PH2_W-1:0] cfg_ph2,
  input  logic [SJW_W-1:0] cfg_jump,
  input  logic             rx,
  input  logic             tx_dom,
  input  logic             hsync_en,
  output logic             tq_tick,
  output logic             sample_stb,
  output logic             sample_bit,
  output logic             bit_start
);
  localparam int PCW = PSC_W + 1;
  localparam int QW  = ((PH1_W > PH2_W) ? PH1_W : PH2_W) + 2;
  localparam logic [QW-1:0]  Q1 = QW'(1);
  localparam logic [PCW-1:0] P1 = PCW'(1);

  typedef enum logic [1:0] {SEG_SYNC, SEG_PH1, SEG_PH2} seg_t;

  seg_t           seg;
  logic [QW-1:0]  cnt, ext, shr;
  logic [PCW-1:0] pcnt;
  logic           done, rx_q;

  wire [PCW-1:0] pmax = PCW'(cfg_div) + P1;
  wire [QW-1:0]  len1 = QW'(cfg_ph1) + Q1;
  wire [QW-1:0]  len2 = QW'(cfg_ph2) + Q1;
  wire [QW-1:0]  jw   = QW'(cfg_jump) + Q1;
  wire [QW-1:0]  sjw  = (jw > len2) ? len2 : jw;

  wire fall   = rx_q & ~rx;
  wire hard   = fall & hsync_en;
  wire resync = fall & ~hsync_en & ~done & ~tx_dom;

  assign tq_tick = (pcnt == pmax);

  wire [QW-1:0] err1 = cnt + Q1;
  wire [QW-1:0] rem2 = len2 - cnt;

  logic [QW-1:0] ext_n, shr_n;
  logic          restart;

  always_comb begin
    ext_n   = ext;
    shr_n   = shr;
    restart = hard;
    if (resync) begin
      case (seg)
        SEG_PH1: ext_n = (err1 > sjw) ? sjw : err1;
        SEG_PH2: begin
          if (rem2 <= sjw) restart = 1'b1;
          else             shr_n   = sjw;
        end
        default: ;
      endcase
    end
  end

  wire end1 = (cnt + Q1) >= (len1 + ext_n);
  wire end2 = (cnt + Q1) >= (len2 - shr_n);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      seg        <= SEG_SYNC;
      cnt        <= '0;
      ext        <= '0;
      shr        <= '0;
      pcnt       <= '0;
      done       <= 1'b0;
      rx_q       <= 1'b1;
      sample_stb <= 1'b0;
      sample_bit <= 1'b1;
      bit_start  <= 1'b0;
    end else begin
      rx_q       <= rx;
      sample_stb <= 1'b0;
      bit_start  <= 1'b0;
      ext        <= ext_n;
      shr        <= shr_n;
      if (resync) done <= 1'b1;
      if (restart) begin
        seg       <= SEG_SYNC;
        cnt       <= '0;
        pcnt      <= '0;
        ext       <= '0;
        shr       <= '0;
        done      <= 1'b1;
        bit_start <= 1'b1;
      end else if (tq_tick) begin
        pcnt <= '0;
        case (seg)
          SEG_SYNC: begin
            seg <= SEG_PH1;
            cnt <= '0;
          end
          SEG_PH1: begin
            if (end1) begin
              seg        <= SEG_PH2;
              cnt        <= '0;
              sample_stb <= 1'b1;
              sample_bit <= rx;
            end else begin
              cnt <= cnt + Q1;
            end
          end
          SEG_PH2: begin
            if (end2) begin
              seg       <= SEG_SYNC;
              cnt       <= '0;
              ext       <= '0;
              shr       <= '0;
              done      <= 1'b0;
              bit_start <= 1'b1;
            end else begin
              cnt <= cnt + Q1;
            end
          end
          default: seg <= SEG_SYNC;
        endcase
      end else begin
        pcnt <= pcnt + P1;
      end
    end
  end
endmodule

// File: rtl/can_bit_timer_chk.sv
module can_bit_timer_chk (
  input logic clk,
  input logic rst_n,
  input logic rx,
  input logic rx_q,
  input logic hsync_en,
  input logic tq_tick,
  input logic sample_stb,
  input logic sample_bit,
  input logic bit_start
);
  AST_TICK_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    tq_tick |=> !tq_tick); // R1

  AST_SAMPLE_AFTER_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    sample_stb |-> $past(tq_tick)); // R3

  AST_SAMPLE_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
    sample_stb |-> (sample_bit == $past(rx))); // R3

  AST_STROBE_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(sample_stb && bit_start)); // R2

  AST_HARD_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(hsync_en) && $past(rx_q) && !$past(rx)) |-> bit_start); // R11

  AST_START_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    bit_start |-> ($past(tq_tick) || ($past(rx_q) && !$past(rx)))); // R2
endmodule

bind can_bit_timer can_bit_timer_chk u_chk (
  .clk(clk), .rst_n(rst_n), .rx(rx), .rx_q(rx_q), .hsync_en(hsync_en),
  .tq_tick(tq_tick), .sample_stb(sample_stb), .sample_bit(sample_bit),
  .bit_start(bit_start)
);

// File: tb/test_can_bit_timer.sv
module test_can_bit_timer;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 150000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [5:0] cdiv = 6'd0;
  logic [3:0] cph1 = 4'd3;
  logic [2:0] cph2 = 3'd2;
  logic [1:0] cjmp = 2'd1;
  logic       rx = 1'b1, txd = 1'b0, hs = 1'b0;
  logic       tq_tick, sample_stb, sample_bit, bit_start;

  can_bit_timer i_can_bit_timer (
    .clk(clk), .rst_n(rst_n), .cfg_div(cdiv), .cfg_ph1(cph1), .cfg_ph2(cph2),
    .cfg_jump(cjmp), .rx(rx), .tx_dom(txd), .hsync_en(hs),
    .tq_tick(tq_tick), .sample_stb(sample_stb), .sample_bit(sample_bit),
    .bit_start(bit_start)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_chk = 0, n_err = 0, cyc = 0;
  int last_bs = 0, prev_bs = 0, edge_cyc = 0;

  // reference model: quantum position within the bit
  int m_q, m_pc, m_ext, m_shr;
  bit m_done, m_rxq, e_st, e_bs, e_sb;
  int m_psc, m_l1, m_l2, m_sjw, m_p1e, m_rem;
  bit m_fall, m_rs, m_rst;

  function automatic int psc_v(); return int'(cdiv) + 2; endfunction
  function automatic int l1_v();  return int'(cph1) + 1; endfunction
  function automatic int l2_v();  return int'(cph2) + 1; endfunction
  function automatic int sjw_v();
    int j = int'(cjmp) + 1;
    return (j > l2_v()) ? l2_v() : j;
  endfunction

  always @(posedge clk) begin
    cyc = cyc + 1;
    if (!rst_n) begin
      m_q = 0; m_pc = 0; m_ext = 0; m_shr = 0; m_done = 0; m_rxq = 1;
      e_st = 0; e_bs = 0; e_sb = 1;
    end else begin
      m_psc = psc_v(); m_l1 = l1_v(); m_l2 = l2_v(); m_sjw = sjw_v();
      e_st = 0; e_bs = 0;
      m_fall = m_rxq && !rx;
      m_rst = m_fall && hs;
      m_rs  = m_fall && !hs && !m_done && !txd;
      if (m_rs) begin
        m_p1e = 1 + m_l1 + m_ext;
        if (m_q == 0) begin
        end else if (m_q < m_p1e) begin
          m_ext = (m_q < m_sjw) ? m_q : m_sjw;
        end else begin
          m_rem = m_p1e + m_l2 - m_q;
          if (m_rem <= m_sjw) m_rst = 1;
          else m_shr = m_sjw;
        end
        m_done = 1;
      end
      if (m_rst) begin
        m_q = 0; m_pc = 0; m_ext = 0; m_shr = 0; m_done = 1; e_bs = 1;
      end else if (m_pc == m_psc - 1) begin
        m_pc = 0;
        m_q = m_q + 1;
        if (m_q == 1 + m_l1 + m_ext) begin
          e_st = 1; e_sb = rx;
        end
        if (m_q == 1 + m_l1 + m_ext + m_l2 - m_shr) begin
          m_q = 0; e_bs = 1; m_ext = 0; m_shr = 0; m_done = 0;
        end
      end else begin
        m_pc = m_pc + 1;
      end
    end
    m_rxq = rst_n ? rx : 1'b1;
  end

  task automatic chk(input bit ok, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: got %0d expected %0d (cycle %0d)", what, act, exp, cyc);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      chk(tq_tick == (m_pc == psc_v() - 1), "R1 tq_tick", tq_tick, int'(m_pc == psc_v() - 1));
      chk(bit_start == e_bs, "R2 bit_start", bit_start, e_bs);
      chk(sample_stb == e_st, "R3 sample_stb", sample_stb, e_st);
      chk(sample_bit == e_sb, "R3 sample_bit", sample_bit, e_sb);
    end
    if (bit_start) begin
      prev_bs <= last_bs;
      last_bs <= cyc;
    end
  end

  always @(posedge clk) begin
    if (cyc > WATCHDOG) begin
      n_chk++; n_err++;
      $display("FAIL R2 watchdog: got %0d cycles expected below %0d", cyc, WATCHDOG);
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  task automatic do_reset(input int d, input int p1, input int p2, input int j);
    @(negedge clk);
    rst_n = 0; rx = 1; txd = 0; hs = 0;
    cdiv = 6'(d); cph1 = 4'(p1); cph2 = 3'(p2); cjmp = 2'(j);
    repeat (3) @(negedge clk);
    chk(!tq_tick && !sample_stb && !bit_start && sample_bit, "R13 reset outputs",
        {28'd0, tq_tick, sample_stb, bit_start, sample_bit}, 1);
    rst_n = 1;
  endtask

  task automatic wait_start();
    do @(negedge clk); while (!bit_start);
    edge_cyc = cyc;
  endtask

  task automatic wait_q(input int t);
    while (!(m_q == t && m_pc == 0)) @(negedge clk);
  endtask

  task automatic pulse(input int t, input int hold);
    wait_q(t);
    rx = 0;
    edge_cyc = cyc;
    repeat (hold) @(negedge clk);
    rx = 1;
  endtask

  task automatic meas(input int exp, input string what);
    while (last_bs <= edge_cyc) @(posedge clk);
    chk(last_bs - prev_bs == exp, what, last_bs - prev_bs, exp);
  endtask

  int nom, t0, lfsr;

  initial begin
    // config A: divisor 2, phase1 4, phase2 3, jump 2
    do_reset(0, 3, 2, 1);
    nom = psc_v() * (1 + l1_v() + l2_v());
    wait_start(); meas(nom, "R2 nominal bit length");
    wait_start(); pulse(4, 2); meas(nom + psc_v() * sjw_v(), "R5 late edge clamped");
    wait_start(); pulse(5, 2); meas(nom - psc_v() * sjw_v(), "R6 early edge clamped");
    wait_start(); pulse(1, 2); meas(nom + psc_v() * 1, "R7 small late full correction");
    wait_start(); pulse(7, 2); meas(psc_v() * 7 + 1, "R7 small early restarts bit");
    txd = 1;
    wait_start(); pulse(4, 2); meas(nom, "R9 edge during own dominant ignored");
    wait_start(); wait_q(1); rx = 0; wait_q(3); txd = 0; wait_q(4); rx = 1;
    meas(nom, "R4 rising edge ignored");
    wait_start(); pulse(1, 2); pulse(5, 2); meas(nom + psc_v(), "R10 second edge ignored");
    wait_start(); pulse(0, 2); meas(nom, "R12 sync segment edge");
    hs = 1;
    wait_start(); pulse(4, 2); meas(psc_v() * 4 + 1, "R11 hard sync restart");
    hs = 0;
    wait_start(); meas(nom, "R2 bit after hard sync");

    // config B: phase2 of 1 quantum caps the jump width
    do_reset(0, 7, 0, 3);
    nom = psc_v() * (1 + l1_v() + l2_v());
    wait_start(); pulse(8, 2); meas(nom + psc_v(), "R8 jump width clamped to phase2");
    wait_start(); pulse(9, 2); meas(psc_v() * 9 + 1, "R8 early edge within clamp");

    // config C: divisor 7, then pseudo-random bus traffic against the model
    do_reset(5, 5, 4, 2);
    do @(negedge clk); while (!tq_tick);
    t0 = cyc;
    do @(negedge clk); while (!tq_tick);
    chk(cyc - t0 == 7, "R1 tick spacing", cyc - t0, 7);
    lfsr = 32'h1ace5;
    for (int i = 0; i < 4000; i++) begin
      @(negedge clk);
      lfsr = (lfsr >> 1) ^ ((lfsr & 1) ? 32'h80200003 : 0);
      if ((lfsr & 32'h3f) == 0) rx = ~rx;
      txd = ((lfsr >> 8) & 32'h1f) == 0;
      hs  = ((lfsr >> 14) & 32'hff) == 0;
    end
    rx = 1; txd = 0; hs = 0;
    repeat (50) @(negedge clk);

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule